// File: doc/BRIEF.md
# Store Queue with Restricted Load Forwarding

This block holds stores that a load/store pipeline has issued but not yet written to the data cache. Each store enters with an address, an access size, up to eight bytes of data and a flag that marks data taken from the upper byte of a register. Stores leave for the cache write port one at a time and strictly oldest first. A store may leave only after the pipeline has confirmed through a commit pulse that it and every older instruction have retired.

Every load looks up the queue in the same cycle. Among the queued stores whose byte range overlaps the load, only the youngest is considered. If that store starts at the same address as the load, is at least as wide, has the upper-byte flag clear, and both accesses are aligned, the load takes its data directly from the store. If the overlap fails any of these tests, the load is stalled until that store has reached the cache. A load that overlaps no queued store goes straight to the cache read port.

Top module: `store_fwd_queue`

## Requirements
- R1: A store is accepted on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low exactly when all `DEPTH` entries (24 by default) are occupied. A store offered while `st_ready` is low is dropped and never reaches the cache port.
- R2: Stores appear on the cache write port in the order they were accepted. `wr_valid` is high exactly when the oldest queued store has been committed.
- R3: Each cycle with `commit_valid` high marks the oldest not-yet-committed queued store as committed. A pulse with no uncommitted store queued has no effect, including on stores accepted later.
- R4: Size code on `st_size`/`ld_size`/`wr_size` is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. When the load forwards (`ld_fwd`=1), `ld_data` holds the store's low-order load-size bytes with all higher bits zero.
- R5: An access is aligned when its address is a multiple of its size. If either the load or the deciding store is misaligned, the load does not forward and `ld_stall` is high.
- R6: If the deciding store has its upper-byte flag set, the load does not forward and `ld_stall` is high.
- R7: If the deciding store starts at a different address from the load, or is narrower than the load, the load does not forward and `ld_stall` is high.
- R8: Overlap is computed on byte ranges. When several queued stores overlap a load, only the most recently accepted one decides between forwarding and stalling.
- R9: For a valid load, exactly one of `ld_fwd`, `ld_stall`, `ld_to_cache` is high. `ld_to_cache` is high when no queued store overlaps, including stores on adjacent bytes. With `ld_valid` low all three are low.
- R10: A stalled load's stall ends as soon as every overlapping store has been written to the cache. The load then goes to the cache.
- R11: At most one store drains per cycle. While `wr_valid` is high and `wr_ready` is low, the write port holds its address, size and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue has a free entry |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | DW | Store data, low bytes significant |
| st_hibyte | input | 1 | Store data came from an upper-byte register |
| commit_valid | input | 1 | Oldest uncommitted store has retired |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | DW | Write data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_fwd | output | 1 | Load served from the queue |
| ld_stall | output | 1 | Load must wait for a store to drain |
| ld_to_cache | output | 1 | Load may read the cache |
| ld_data | output | DW | Forwarded data, zero-extended |

## Verification
The assertions check on every cycle that backpressure matches an occupancy count rebuilt from the handshakes, that the write request follows a commit count rebuilt from the ports, and that a blocked write holds still. They also check that exactly one load outcome is raised, and that forwarded data is zero above the load size and comes only from an aligned load. Only the bench scenarios can show whether the right store decides a load, which of the eligibility rules forces a stall, the drain order, the end of a stall after the blocking store leaves, and that commits issued on an empty queue have no effect.

// File: rtl/stq_pkg.sv
// Package: shared size encoding and helpers for the store queue.
// Assumes sizes are powers of two from 1 to 8 bytes.
package stq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // True when the low three address bits are a multiple of the access size.
    function automatic logic is_aligned(input logic [2:0] lo, input logic [1:0] sz);
        logic [3:0] span_m1;
        span_m1 = (4'd1 << sz) - 4'd1;
        return (({1'b0, lo} & span_m1) == 4'd0);
    endfunction

endpackage

// File: rtl/stq_ctrl.sv
// Module: pointer, occupancy and commit bookkeeping for the circular queue.
// Assumes deq is only raised while at least one committed entry exists.
module stq_ctrl #(
    parameter int DEPTH = 24,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic          deq,
    input  logic          commit_valid,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          has_committed
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [CW-1:0] cmt_count;
    logic          cmt_inc;

    // A commit only counts while some queued store is still uncommitted.
    always_comb begin
        cmt_inc = commit_valid && (cmt_count < count);
    end

    assign full          = (count == CW'(DEPTH));
    assign has_committed = (cmt_count != '0);

    // Advance pointers and counters on enqueue, dequeue and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head      <= '0;
            tail      <= '0;
            count     <= '0;
            cmt_count <= '0;
        end else begin
            if (enq) tail <= (tail == LAST) ? '0 : tail + PW'(1);
            if (deq) head <= (head == LAST) ? '0 : head + PW'(1);
            count     <= count + CW'(enq) - CW'(deq);
            cmt_count <= cmt_count + CW'(cmt_inc) - CW'(deq);
        end
    end

endmodule

// File: rtl/stq_storage.sv
// Module: entry storage for queued stores, written at the tail and read at
// the head; every entry is exposed for the load search.
// Assumes the controller never writes a full queue.
module stq_storage #(
    parameter int DEPTH = 24,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] in_addr,
    input  logic [1:0]    in_size,
    input  logic [DW-1:0] in_data,
    input  logic          in_hib,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] e_addr [DEPTH],
    output logic [1:0]    e_size [DEPTH],
    output logic [DW-1:0] e_data [DEPTH],
    output logic          e_hib  [DEPTH]
);
    // Capture a new store into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_addr[wr_idx] <= in_addr;
            e_size[wr_idx] <= in_size;
            e_data[wr_idx] <= in_data;
            e_hib[wr_idx]  <= in_hib;
        end
    end

    // Present the oldest entry to the cache write port.
    always_comb begin
        rd_addr = e_addr[rd_idx];
        rd_size = e_size[rd_idx];
        rd_data = e_data[rd_idx];
    end

endmodule

// File: rtl/stq_match.sv
// Module: load search. Finds the youngest queued store whose byte range
// overlaps the load and decides forward, stall or cache access.
// Assumes entries outside head..head+count-1 are stale and ignores them.
module stq_match
    import stq_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NB = DW / 8
) (
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] e_addr [DEPTH],
    input  logic [1:0]    e_size [DEPTH],
    input  logic [DW-1:0] e_data [DEPTH],
    input  logic          e_hib  [DEPTH],
    output logic          ld_fwd,
    output logic          ld_stall,
    output logic          ld_to_cache,
    output logic [DW-1:0] ld_data
);
    logic [DEPTH-1:0] ovl;
    logic [DEPTH-1:0] elig;
    logic [AW:0]      ld_lo;
    logic [AW:0]      ld_hi;
    logic             ld_al;
    logic             hit;
    logic [PW-1:0]    sel;
    logic [DW-1:0]    keep;

    // Load byte range as a half-open interval, one extra bit for carry.
    always_comb begin
        ld_lo = {1'b0, ld_addr};
        ld_hi = ld_lo + ((AW + 1)'(1) << ld_size);
        ld_al = is_aligned(ld_addr[2:0], ld_size);
    end

    // Per-slot overlap and forwarding eligibility.
    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        logic [AW:0] s_lo;
        logic [AW:0] s_hi;
        assign s_lo    = {1'b0, e_addr[j]};
        assign s_hi    = s_lo + ((AW + 1)'(1) << e_size[j]);
        assign ovl[j]  = (ld_lo < s_hi) && (s_lo < ld_hi);
        assign elig[j] = (e_addr[j] == ld_addr) && (ld_size <= e_size[j]) &&
                         ld_al && is_aligned(e_addr[j][2:0], e_size[j]) &&
                         !e_hib[j];
    end

    // Walk from oldest to youngest; the last overlapping slot wins.
    always_comb begin
        logic [PW:0] idx_w;
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx_w = {1'b0, head} + (PW + 1)'(i);
            if (idx_w >= (PW + 1)'(DEPTH)) idx_w = idx_w - (PW + 1)'(DEPTH);
            if ((CW'(i) < count) && ovl[idx_w[PW-1:0]]) begin
                hit = 1'b1;
                sel = idx_w[PW-1:0];
            end
        end
    end

    // Byte mask covering the load size, used to zero-extend forwarded data.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            keep[b*8 +: 8] = (b < (1 << ld_size)) ? 8'hFF : 8'h00;
        end
    end

    // Final load outcome.
    always_comb begin
        ld_fwd      = ld_valid && hit && elig[sel];
        ld_stall    = ld_valid && hit && !elig[sel];
        ld_to_cache = ld_valid && !hit;
        ld_data     = ld_fwd ? (e_data[sel] & keep) : '0;
    end

endmodule

// File: rtl/store_fwd_queue.sv
// Module: in-order store queue with restricted store-to-load forwarding.
// Stores drain oldest first once committed; loads forward, stall or go to
// the cache. Assumes DW is 64 so that the largest size code fills the data.
module store_fwd_queue #(
    parameter int DEPTH = 24,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [1:0]    st_size,
    input  logic [DW-1:0] st_data,
    input  logic          st_hibyte,
    input  logic          commit_valid,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [DW-1:0] wr_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    output logic          ld_fwd,
    output logic          ld_stall,
    output logic          ld_to_cache,
    output logic [DW-1:0] ld_data
);
    logic [PW-1:0] head;
    logic [PW-1:0] tail;
    logic [CW-1:0] count;
    logic          full;
    logic          has_cmt;
    logic          enq;
    logic          deq;
    logic [AW-1:0] e_addr [DEPTH];
    logic [1:0]    e_size [DEPTH];
    logic [DW-1:0] e_data [DEPTH];
    logic          e_hib  [DEPTH];

    // Handshakes at the queue edges.
    always_comb begin
        st_ready = !full;
        enq      = st_valid && !full;
        wr_valid = has_cmt;
        deq      = has_cmt && wr_ready;
    end

    stq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enq           (enq),
        .deq           (deq),
        .commit_valid  (commit_valid),
        .head          (head),
        .tail          (tail),
        .count         (count),
        .full          (full),
        .has_committed (has_cmt)
    );

    stq_storage #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (enq),
        .wr_idx  (tail),
        .in_addr (st_addr),
        .in_size (st_size),
        .in_data (st_data),
        .in_hib  (st_hibyte),
        .rd_idx  (head),
        .rd_addr (wr_addr),
        .rd_size (wr_size),
        .rd_data (wr_data),
        .e_addr  (e_addr),
        .e_size  (e_size),
        .e_data  (e_data),
        .e_hib   (e_hib)
    );

    stq_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_size     (ld_size),
        .head        (head),
        .count       (count),
        .e_addr      (e_addr),
        .e_size      (e_size),
        .e_data      (e_data),
        .e_hib       (e_hib),
        .ld_fwd      (ld_fwd),
        .ld_stall    (ld_stall),
        .ld_to_cache (ld_to_cache),
        .ld_data     (ld_data)
    );

endmodule

// File: rtl/stq_checker.sv
// Module: property checker for store_fwd_queue, rebuilding occupancy and
// commit counts from port handshakes only. Attached by bind below.
module stq_checker #(
    parameter int DEPTH = 24,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          commit_valid,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    wr_size,
    input logic [DW-1:0] wr_data,
    input logic          ld_valid,
    input logic [2:0]    ld_addr_lo,
    input logic [1:0]    ld_size,
    input logic          ld_fwd,
    input logic          ld_stall,
    input logic          ld_to_cache,
    input logic [DW-1:0] ld_data
);
    logic [CW-1:0] occ;
    logic [CW-1:0] cmt;
    logic          acc;
    logic          drn;

    assign acc = st_valid && st_ready;
    assign drn = wr_valid && wr_ready;

    // Shadow occupancy and commit counts from the port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
            cmt <= '0;
        end else begin
            occ <= occ + CW'(acc) - CW'(drn);
            cmt <= cmt + CW'(commit_valid && (cmt < occ)) - CW'(drn);
        end
    end

    p_full_noready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !st_ready);
    p_room_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < CW'(DEPTH)) |-> st_ready);
    p_commit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt == '0) |-> !wr_valid);
    p_commit_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt != '0) |-> wr_valid);
    p_drain_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                     $stable(wr_size) && $stable(wr_data)));
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $onehot({ld_fwd, ld_stall, ld_to_cache}));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !(ld_fwd || ld_stall || ld_to_cache));
    p_fwd_zeroext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> ((ld_data >> (8 << ld_size)) == '0));
    p_fwd_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> (({1'b0, ld_addr_lo} & ((4'd1 << ld_size) - 4'd1)) == 4'd0));

endmodule

bind store_fwd_queue stq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .commit_valid (commit_valid),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_size      (wr_size),
    .wr_data      (wr_data),
    .ld_valid     (ld_valid),
    .ld_addr_lo   (ld_addr[2:0]),
    .ld_size      (ld_size),
    .ld_fwd       (ld_fwd),
    .ld_stall     (ld_stall),
    .ld_to_cache  (ld_to_cache),
    .ld_data      (ld_data)
);

// File: tb/store_fwd_queue_bench.sv
// Directed bench for store_fwd_queue: one task per scenario.
// Inputs change on the falling edge; outputs are sampled 1 ns later.
module store_fwd_queue_bench;
    localparam int DEPTH = 24;
    localparam int AW    = 32;
    localparam int DW    = 64;
    localparam int K_GO = 0, K_FWD = 1, K_STALL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [1:0]    st_size = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_hibyte = 1'b0;
    logic          commit_valid = 1'b0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [1:0]    wr_size;
    logic [DW-1:0] wr_data;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [1:0]    ld_size = '0;
    logic          ld_fwd;
    logic          ld_stall;
    logic          ld_to_cache;
    logic [DW-1:0] ld_data;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [63:0] D0 = 64'h1122334455667788;
    localparam logic [63:0] E5 = 64'hA1B2C3D4E5F60718;

    always #4 clk = ~clk;

    store_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store_fwd_queue (.*);

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        st_valid = 0; commit_valid = 0; wr_ready = 0; ld_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [31:0] a, input logic [1:0] s,
                        input logic [63:0] d, input logic hb);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_size = s; st_data = d; st_hibyte = hb;
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] s, input int kind,
                         input logic [63:0] exp_d, input string tag);
        logic [2:0] exp_k;
        @(negedge clk);
        ld_valid = 1; ld_addr = a; ld_size = s;
        #1;
        exp_k = (kind == K_FWD) ? 3'b100 : (kind == K_STALL) ? 3'b010 : 3'b001;
        chk({61'd0, ld_fwd, ld_stall, ld_to_cache}, {61'd0, exp_k}, tag);
        if (kind == K_FWD) chk(ld_data, exp_d, tag);
        ld_valid = 0;
    endtask

    task automatic drain_one(output logic [31:0] a, output logic [63:0] d);
        @(negedge clk);
        wr_ready = 1;
        #1;
        chk({63'd0, wr_valid}, 64'd1, "R2 wr_valid before drain");
        a = wr_addr; d = wr_data;
        @(posedge clk);
        #1 wr_ready = 0;
    endtask

    // R1: reset state, fill to DEPTH, drop an offered store while full.
    task automatic t_fill();
        logic [31:0] a;
        int n;
        do_reset();
        #1;
        chk({63'd0, st_ready}, 64'd1, "R1 ready after reset");
        chk({63'd0, wr_valid}, 64'd0, "R2 no write after reset");
        chk({61'd0, ld_fwd, ld_stall, ld_to_cache}, 64'd0, "R9 idle outputs");
        for (int i = 0; i < DEPTH; i++) push(32'(i * 8), 2'd3, 64'(i), 1'b0);
        #1 chk({63'd0, st_ready}, 64'd0, "R1 full backpressure");
        push(32'hF00, 2'd3, 64'hDEAD, 1'b0);
        @(negedge clk);
        commit_valid = 1; wr_ready = 1;
        n = 0;
        for (int c = 0; c < 60; c++) begin
            #1;
            if (wr_valid) begin
                a = wr_addr;
                if (n < DEPTH) chk(64'(a), 64'(n * 8), "R2 drain order after fill");
                else chk(64'(a), 64'hFFFF_FFFF, "R1 dropped store drained");
                n++;
            end
            @(negedge clk);
        end
        commit_valid = 0; wr_ready = 0;
        chk(64'(n), 64'(DEPTH), "R1 drained count");
        chk({63'd0, st_ready}, 64'd1, "R1 ready after drain");
    endtask

    // R3: commits on an empty queue do not pre-commit later stores.
    task automatic t_empty_commit();
        do_reset();
        @(negedge clk);
        commit_valid = 1;
        repeat (3) @(negedge clk);
        commit_valid = 0;
        push(32'h40, 2'd2, 64'h55, 1'b0);
        #1 chk({63'd0, wr_valid}, 64'd0, "R3 stale commit ignored");
        commit_valid = 1;
        @(negedge clk);
        commit_valid = 0;
        #1 chk({63'd0, wr_valid}, 64'd1, "R3 commit opens drain");
    endtask

    // R4-R10: forwarding rules, youngest match, then ordered drain.
    task automatic t_forward();
        logic [31:0] a;
        logic [63:0] d;
        do_reset();
        push(32'h100, 2'd3, D0, 1'b0);
        probe(32'h100, 2'd2, K_FWD, 64'h55667788, "R4 narrow forward");
        probe(32'h100, 2'd3, K_FWD, D0, "R4 full forward");
        push(32'h200, 2'd1, 64'hBEEF, 1'b0);
        probe(32'h200, 2'd2, K_STALL, 0, "R7 load wider than store");
        probe(32'h201, 2'd0, K_STALL, 0, "R7 different start");
        push(32'h300, 2'd0, 64'h7A, 1'b1);
        probe(32'h300, 2'd0, K_STALL, 0, "R6 high-byte store");
        push(32'h402, 2'd2, 64'h9999, 1'b0);
        probe(32'h402, 2'd2, K_STALL, 0, "R5 misaligned pair");
        probe(32'h900, 2'd3, K_GO, 0, "R9 no overlap");
        probe(32'h108, 2'd3, K_GO, 0, "R9 adjacent above");
        probe(32'h0F8, 2'd3, K_GO, 0, "R9 adjacent below");
        push(32'h100, 2'd0, 64'h33, 1'b1);
        probe(32'h100, 2'd0, K_STALL, 0, "R8 youngest blocks");
        push(32'h100, 2'd3, E5, 1'b0);
        probe(32'h100, 2'd0, K_FWD, 64'h18, "R8 youngest forwards");
        probe(32'h100, 2'd1, K_FWD, 64'h0718, "R4 half forward");
        #1 chk({63'd0, wr_valid}, 64'd0, "R2 uncommitted held");
        @(negedge clk);
        commit_valid = 1;
        repeat (6) @(negedge clk);
        commit_valid = 0;
        #1 chk({31'd0, wr_valid, wr_addr}, {31'd0, 1'b1, 32'h100}, "R11 request shown");
        @(negedge clk);
        #1 chk({31'd0, wr_valid, wr_addr}, {31'd0, 1'b1, 32'h100}, "R11 request held");
        chk(wr_data, D0, "R11 data held");
        drain_one(a, d);
        chk(64'(a), 64'h100, "R2 first drained");
        probe(32'h200, 2'd2, K_STALL, 0, "R10 still blocked");
        drain_one(a, d);
        chk(64'(a), 64'h200, "R2 second drained");
        probe(32'h200, 2'd2, K_GO, 0, "R10 stall released");
        drain_one(a, d);
        chk(64'(a), 64'h300, "R2 third drained");
        drain_one(a, d);
        chk(64'(a), 64'h402, "R2 fourth drained");
        drain_one(a, d);
        chk(64'(a), 64'h100, "R2 fifth drained");
        drain_one(a, d);
        chk(64'(a), 64'h100, "R2 sixth drained");
        chk(d, E5, "R2 last data");
        #1 chk({63'd0, wr_valid}, 64'd0, "R2 queue empty");
        probe(32'h100, 2'd3, K_GO, 0, "R10 cache after drain");
    endtask

    initial begin
        t_fill();
        t_empty_commit();
        t_forward();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule